// File: doc/BRIEF.md
# Multi-Size Translation Buffer with Domain and Sub-Page Access Checks

This block is a fully associative address translation cache. A lookup port presents a 32-bit virtual address together with a write flag and a privilege flag. In the same cycle the block returns a spliced physical address with a valid flag, or a miss, or an abort. Each stored entry maps a 1 MB section, a 64 KB large page or a 4 KB small page. Each entry carries a 4-bit domain number and up to four 2-bit permission fields. Small pages and large pages use one field per quarter of the page. Sections use a single field.

An external table walker answers a miss through a one-cycle refill port. The refill lands in the slot named by a round-robin pointer, and the lookup stays in the miss state until that entry is present. The domain control word and the enable bit are plain inputs. With the enable bit low, addresses pass straight through and no lookup is made. A flush input invalidates every slot in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: While `mmu_on` is low, a lookup drives `pa` equal to `lk_va` with `pa_valid` high, and `miss` and `abort` stay low, whatever the stored entries hold.
- R2: `fill_size` is encoded as 00 = 4 KB small page (tag is VA[31:12]), 01 = 64 KB large page (tag is VA[31:16]), 10 = 1 MB section (tag is VA[31:20]), and 11 = an entry that never matches. A lookup hits only if the tag bits of that entry's size are equal.
- R3: On a permitted hit, `pa` takes the physical base bits above the entry's block size, and the lookup address supplies the bits below it.
- R4: `fill_ap` holds four 2-bit fields, with field k in bits [2k+1:2k]. A small page selects field VA[11:10]. A large page selects field VA[15:14]. A section always uses field 0.
- R5: The domain field for domain d is `dom_ctrl[2d+1:2d]`. Its codes are 00 = abort, 01 = check permissions, 10 = abort, and 11 = allow without a permission check.
- R6: The permission codes are 00 = abort always, 01 = privileged only, 10 = privileged read/write with user read only, and 11 = full access. A user write to code 10 aborts.
- R7: While enabled, a lookup that matches no valid entry raises `miss`. The miss persists in the cycle in which the refill is presented, and the lookup hits in the cycle after the refill is written.
- R8: Refills are written to slots 0, 1, 2, … in turn, and the pointer wraps after 32 slots. The 33rd refill after a flush replaces the first one.
- R9: A `flush` pulse invalidates all entries by the next cycle and returns the refill pointer to slot 0.
- R10: If several valid entries match, the one with the lowest slot index supplies the result.
- R11: `pa_valid`, `miss` and `abort` are mutually exclusive. `pa_valid` is low whenever `abort` is high.
- R12: After reset every slot is invalid, so an enabled lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_on | input | 1 | Translation enable; low passes addresses through |
| dom_ctrl | input | 32 | Domain control word, 2 bits per domain |
| flush | input | 1 | Invalidate all entries, reset refill pointer |
| lk_valid | input | 1 | Lookup request present |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write |
| lk_priv | input | 1 | Lookup is privileged |
| fill_valid | input | 1 | Refill entry present this cycle |
| fill_size | input | 2 | Mapping size of the refill |
| fill_va | input | 32 | Virtual base of the refill |
| fill_pa | input | 32 | Physical base of the refill |
| fill_dom | input | 4 | Domain number of the refill |
| fill_ap | input | 8 | Four 2-bit permission fields |
| pa | output | 32 | Physical address |
| pa_valid | output | 1 | Physical address is valid |
| miss | output | 1 | No matching entry; table walk needed |
| abort | output | 1 | Access refused |

## Verification
The bench builds the block with its default parameters: 32 slots and 16 domains. With these values the bench can fill one entry past the slot count and observe the wrap, which drives the pointer over its last value and back to zero. Sixteen domains leave room for all four domain codes and all four permission codes to appear together, on entries of each of the three sizes. Duplicate tags in two slots exercise the priority order.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
   localparam int VA_W       = 32;
   localparam int SMALL_SH   = 12;
   localparam int LARGE_SH   = 16;
   localparam int SECT_SH    = 20;
   localparam int SUB_S_LSB  = 10;
   localparam int SUB_L_LSB  = 14;
   localparam int VPN_W      = VA_W - SMALL_SH;
   localparam int AP_FIELDS  = 4;
   localparam int AP_W       = 2 * AP_FIELDS;

   typedef enum logic [1:0] {
      MAP_SMALL   = 2'b00,
      MAP_LARGE   = 2'b01,
      MAP_SECTION = 2'b10,
      MAP_NONE    = 2'b11
   } map_size_e;

   typedef struct packed {
      logic             vld;
      map_size_e        size;
      logic [VPN_W-1:0] vpn;
      logic [VPN_W-1:0] ppn;
      logic [3:0]       dom;
      logic [AP_W-1:0]  ap;
   } tlb_ent_t;

   function automatic logic [1:0] ap_field(input logic [AP_W-1:0] ap, input logic [1:0] sel);
      logic [1:0] r;
      case (sel)
         2'd0:    r = ap[1:0];
         2'd1:    r = ap[3:2];
         2'd2:    r = ap[5:4];
         default: r = ap[7:6];
      endcase
      return r;
   endfunction
endpackage

// File: rtl/xtlb_match.sv
module xtlb_match
   import xtlb_pkg::*;
(
   input  tlb_ent_t        ent,
   input  logic [VA_W-1:0] va,
   output logic            hit,
   output logic [VA_W-1:0] pa,
   output logic [1:0]      ap_sel
);
   localparam int L_DROP = LARGE_SH - SMALL_SH;
   localparam int S_DROP = SECT_SH - SMALL_SH;

   always_comb begin
      hit    = 1'b0;
      pa     = '0;
      ap_sel = 2'b00;
      case (ent.size)
         MAP_SMALL: begin
            hit    = ent.vld && (va[VA_W-1:SMALL_SH] == ent.vpn);
            pa     = {ent.ppn, va[SMALL_SH-1:0]};
            ap_sel = ap_field(ent.ap, va[SUB_S_LSB+1:SUB_S_LSB]);
         end
         MAP_LARGE: begin
            hit    = ent.vld && (va[VA_W-1:LARGE_SH] == ent.vpn[VPN_W-1:L_DROP]);
            pa     = {ent.ppn[VPN_W-1:L_DROP], va[LARGE_SH-1:0]};
            ap_sel = ap_field(ent.ap, va[SUB_L_LSB+1:SUB_L_LSB]);
         end
         MAP_SECTION: begin
            hit    = ent.vld && (va[VA_W-1:SECT_SH] == ent.vpn[VPN_W-1:S_DROP]);
            pa     = {ent.ppn[VPN_W-1:S_DROP], va[SECT_SH-1:0]};
            ap_sel = ent.ap[1:0];
         end
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/xtlb_pick.sv
module xtlb_pick #(
   parameter int N = 32,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  hit_vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/xtlb_access.sv
module xtlb_access #(
   parameter int DOM_N = 16,
   localparam int DW = (DOM_N > 1) ? $clog2(DOM_N) : 1
) (
   input  logic [2*DOM_N-1:0] dom_ctrl,
   input  logic [DW-1:0]      dom,
   input  logic [1:0]         ap,
   input  logic               priv,
   input  logic               write,
   output logic               allow
);
   logic [1:0] dfield;
   logic       perm_ok;

   assign dfield = dom_ctrl[2*dom +: 2];

   always_comb begin
      case (ap)
         2'b00:   perm_ok = 1'b0;
         2'b01:   perm_ok = priv;
         2'b10:   perm_ok = priv || !write;
         default: perm_ok = 1'b1;
      endcase
   end

   always_comb begin
      case (dfield)
         2'b01:   allow = perm_ok;
         2'b11:   allow = 1'b1;
         default: allow = 1'b0;
      endcase
   end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xtlb_pkg::*;
#(
   parameter int NUM_ENTRIES = 32,
   parameter int DOM_N       = 16,
   localparam int PTR_W      = $clog2(NUM_ENTRIES),
   localparam int DW         = $clog2(DOM_N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mmu_on,
   input  logic [2*DOM_N-1:0] dom_ctrl,
   input  logic               flush,
   input  logic               lk_valid,
   input  logic [VA_W-1:0]    lk_va,
   input  logic               lk_write,
   input  logic               lk_priv,
   input  logic               fill_valid,
   input  logic [1:0]         fill_size,
   input  logic [VA_W-1:0]    fill_va,
   input  logic [VA_W-1:0]    fill_pa,
   input  logic [DW-1:0]      fill_dom,
   input  logic [AP_W-1:0]    fill_ap,
   output logic [VA_W-1:0]    pa,
   output logic               pa_valid,
   output logic               miss,
   output logic               abort
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_ENTRIES - 1);

   initial begin
      assert (NUM_ENTRIES >= 2) else $error("NUM_ENTRIES must be at least 2");
      assert (DOM_N >= 2 && DOM_N <= 16) else $error("DOM_N out of range");
      assert (2 ** DOM_N > 0) else $error("DOM_N invalid");
   end

   tlb_ent_t             ents [NUM_ENTRIES];
   logic [PTR_W-1:0]     ptr;
   logic [NUM_ENTRIES-1:0] hit_vec;
   logic [NUM_ENTRIES-1:0] vld_vec;
   logic [VA_W-1:0]      pa_arr [NUM_ENTRIES];
   logic [1:0]           ap_arr [NUM_ENTRIES];
   logic                 found;
   logic [PTR_W-1:0]     sel;
   logic                 allow;
   logic                 on_req;

   // storage and round-robin replacement
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
      end else if (flush) begin
         ptr <= '0;
         for (int i = 0; i < NUM_ENTRIES; i++) ents[i].vld <= 1'b0;
      end else if (fill_valid) begin
         ents[ptr].vld  <= 1'b1;
         ents[ptr].size <= map_size_e'(fill_size);
         ents[ptr].vpn  <= fill_va[VA_W-1:SMALL_SH];
         ents[ptr].ppn  <= fill_pa[VA_W-1:SMALL_SH];
         ents[ptr].dom  <= 4'(fill_dom);
         ents[ptr].ap   <= fill_ap;
         ptr            <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end

   // per-slot comparators
   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      xtlb_match u_match (
         .ent    (ents[g]),
         .va     (lk_va),
         .hit    (hit_vec[g]),
         .pa     (pa_arr[g]),
         .ap_sel (ap_arr[g])
      );
      assign vld_vec[g] = ents[g].vld;
   end

   xtlb_pick #(.N(NUM_ENTRIES)) u_pick (
      .hit_vec (hit_vec),
      .found   (found),
      .idx     (sel)
   );

   xtlb_access #(.DOM_N(DOM_N)) u_access (
      .dom_ctrl (dom_ctrl),
      .dom      (DW'(ents[sel].dom)),
      .ap       (ap_arr[sel]),
      .priv     (lk_priv),
      .write    (lk_write),
      .allow    (allow)
   );

   assign on_req = lk_valid && mmu_on;

   always_comb begin
      if (!mmu_on) begin
         pa       = lk_va;
         pa_valid = lk_valid;
         miss     = 1'b0;
         abort    = 1'b0;
      end else begin
         miss     = on_req && !found;
         abort    = on_req && found && !allow;
         pa_valid = on_req && found && allow;
         pa       = pa_valid ? pa_arr[sel] : '0;
      end
   end

   // R8: pointer steps by one per refill and wraps after the last slot
   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && !flush |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

   // R9: flush empties every slot and rewinds the pointer
   p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ptr == '0) && (vld_vec == '0));

   // R11: result flags never overlap
   p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({pa_valid, miss, abort}) <= 1);

   // R7: a miss with no refill and no flush stays a miss for the same request
   p_miss_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      miss && !fill_valid && !flush |=>
         !(mmu_on && lk_valid && lk_va == $past(lk_va)) || miss);

   // R1: disabled unit never reports miss or abort
   p_pass_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !mmu_on |-> !miss && !abort);
endmodule

// File: tb/xlat_tlb_bench.sv
module xlat_tlb_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mmu_on = 1'b0;
   logic [31:0] dom_ctrl = 32'h0000_0234;
   logic        flush = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_va = '0;
   logic        lk_write = 1'b0;
   logic        lk_priv = 1'b0;
   logic        fill_valid = 1'b0;
   logic [1:0]  fill_size = '0;
   logic [31:0] fill_va = '0;
   logic [31:0] fill_pa = '0;
   logic [3:0]  fill_dom = '0;
   logic [7:0]  fill_ap = '0;
   logic [31:0] pa;
   logic        pa_valid, miss, abort;

   typedef struct {
      logic [31:0] pa;
      logic        v;
      logic        m;
      logic        a;
      string       req;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   xlat_tlb u_xlat_tlb (
      .clk, .rst_n, .mmu_on, .dom_ctrl, .flush,
      .lk_valid, .lk_va, .lk_write, .lk_priv,
      .fill_valid, .fill_size, .fill_va, .fill_pa, .fill_dom, .fill_ap,
      .pa, .pa_valid, .miss, .abort
   );

   task automatic look(input logic [31:0] va, input logic wr, input logic pv,
                       input logic [31:0] epa, input logic ev, input logic em,
                       input logic ea, input string req);
      exp_t e;
      @(negedge clk);
      fill_valid = 1'b0;
      lk_valid = 1'b1; lk_va = va; lk_write = wr; lk_priv = pv;
      e.pa = epa; e.v = ev; e.m = em; e.a = ea; e.req = req;
      q.push_back(e);
   endtask

   task automatic fill(input logic [1:0] sz, input logic [31:0] va, input logic [31:0] pba,
                       input logic [3:0] dm, input logic [7:0] ap);
      @(negedge clk);
      lk_valid = 1'b0;
      fill_valid = 1'b1; fill_size = sz; fill_va = va; fill_pa = pba;
      fill_dom = dm; fill_ap = ap;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // monitor: compare outputs against the queue head a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (pa_valid !== e.v || miss !== e.m || abort !== e.a ||
                (e.v && pa !== e.pa)) begin
               n_bad++;
               $display("FAIL %s: got pa=%h v=%b m=%b a=%b, expected pa=%h v=%b m=%b a=%b",
                        e.req, pa, pa_valid, miss, abort, e.pa, e.v, e.m, e.a);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      mmu_on = 1'b1;
      // R12: empty after reset
      look(32'h0001_2000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R12");

      // slot0: small page, domain 1 (client), fields {11,10,01,00}
      fill(2'b00, 32'h0001_2000, 32'h8003_4000, 4'd1, 8'hE4);
      look(32'h0001_2C04, 1'b1, 1'b0, 32'h8003_4C04, 1'b1, 1'b0, 1'b0, "R3 R4 R6 full");
      look(32'h0001_2800, 1'b0, 1'b0, 32'h8003_4800, 1'b1, 1'b0, 1'b0, "R6 user read ro");
      look(32'h0001_2800, 1'b1, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R6 user write ro");
      look(32'h0001_2400, 1'b1, 1'b1, 32'h8003_4400, 1'b1, 1'b0, 1'b0, "R6 priv only");
      look(32'h0001_2400, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R6 user on priv");
      look(32'h0001_2000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, "R4 R11 none");

      // slot1: large page, field 1 full access
      fill(2'b01, 32'h0045_0000, 32'h9ABC_0000, 4'd1, 8'h0C);
      look(32'h0045_4321, 1'b1, 1'b0, 32'h9ABC_4321, 1'b1, 1'b0, 1'b0, "R2 R3 R4 large");
      look(32'h0045_C321, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, "R4 large sub3");
      look(32'h0046_0000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R2 large bound");

      // slot2: section in manager domain with no permissions
      fill(2'b10, 32'h1230_0000, 32'h4560_0000, 4'd2, 8'h00);
      look(32'h123A_BCDE, 1'b1, 1'b0, 32'h456A_BCDE, 1'b1, 1'b0, 1'b0, "R5 manager");
      // slot3: domain 3 no access; slot4: domain 4 reserved
      fill(2'b10, 32'h2000_0000, 32'h3000_0000, 4'd3, 8'hFF);
      fill(2'b10, 32'h2100_0000, 32'h3100_0000, 4'd4, 8'hFF);
      look(32'h2000_0010, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, "R5 no access");
      look(32'h2100_0010, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, "R5 reserved");

      // R1: disabled passthrough
      @(negedge clk); mmu_on = 1'b0;
      look(32'h0001_2000, 1'b0, 1'b1, 32'h0001_2000, 1'b1, 1'b0, 1'b0, "R1 over abort");
      look(32'h7777_7777, 1'b1, 1'b0, 32'h7777_7777, 1'b1, 1'b0, 1'b0, "R1 over miss");
      @(negedge clk); mmu_on = 1'b1;

      // R7: pending miss until refill
      look(32'h5551_0000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R7 miss");
      look(32'h5551_0000, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, "R7 still miss");
      begin
         exp_t e;
         @(negedge clk);
         fill_valid = 1'b1; fill_size = 2'b10; fill_va = 32'h5550_0000;
         fill_pa = 32'h6660_0000; fill_dom = 4'd2; fill_ap = 8'h00;
         e.pa = 32'h0; e.v = 1'b0; e.m = 1'b1; e.a = 1'b0; e.req = "R7 refill cycle";
         q.push_back(e);
      end
      look(32'h5551_0000, 1'b0, 1'b0, 32'h6661_0000, 1'b1, 1'b0, 1'b0, "R7 after refill");

      // R10: duplicate tag in slot6 loses to slot0
      fill(2'b00, 32'h0001_2000, 32'hAAAA_A000, 4'd2, 8'h00);
      look(32'h0001_2C04, 1'b0, 1'b1, 32'h8003_4C04, 1'b1, 1'b0, 1'b0, "R10 lowest");
      // R2: size code 11 never matches
      fill(2'b11, 32'h7000_0000, 32'h7000_0000, 4'd2, 8'hFF);
      look(32'h7000_0000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R2 none size");

      // R9: flush
      @(negedge clk); lk_valid = 1'b0; flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      look(32'h123A_BCDE, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R9 flushed");

      // R8: 33 refills wrap over the first
      for (int i = 0; i < 33; i++)
         fill(2'b00, 32'h0100_0000 + (i << 12), 32'h0200_0000 + (i << 12), 4'd2, 8'h00);
      look(32'h0100_0000, 1'b0, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, "R8 overwritten");
      look(32'h0100_1008, 1'b0, 1'b1, 32'h0200_1008, 1'b1, 1'b0, 1'b0, "R8 second kept");
      look(32'h0101_F00C, 1'b0, 1'b1, 32'h0201_F00C, 1'b1, 1'b0, 1'b0, "R8 slot31");
      look(32'h0102_0004, 1'b0, 1'b1, 32'h0202_0004, 1'b1, 1'b0, 1'b0, "R8 wrapped");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule